// File: doc/BRIEF.md
# Soft-Decision Decoder Bus Register Block

This block is the bus-facing register file in front of an iterative soft-input error-correction decoder engine. A host processor reaches it as a Wishbone slave with 32-bit word accesses. The host loads the channel soft values into a 256-entry store of 6-bit signed log-likelihood ratios. Each bus write carries five values, so the whole frame takes 52 writes.

After loading the frame, the host writes the control word to launch a decode and polls the busy flag. When busy clears, it reads the result fields and the 32 decoded bits. The engine itself is outside this block. It sees a one-cycle start pulse, the configuration that was latched at that pulse, and a read port into the soft-value store. It reports back through a done strobe and its result inputs.

Reads and writes decode different maps. In the write map, offsets 0x50 and 0x54 fall inside the soft-value window. In the read map, the same offsets return the decoded bits and a fixed identification word.

Top module: `sdec_bus_regs`

## Requirements
- R1: Every access with CYC and STB both high is acknowledged by a single-cycle ACK in the next cycle, and read data is valid while ACK is high.
- R2: A write at byte offset 0x10+4w (w from 0 to 51) stores bits [6k+5:6k] into soft value 5w+k for k = 0..4, and bits [31:30] are ignored.
- R3: A write at offset 0xDC (w = 51) stores only soft value 255 from bits [5:0], and leaves the other entries unchanged.
- R4: A write at 0x50 or 0x54 fills soft values 80..84 or 85..89. A read at 0x50 returns the decoded bits and a read at 0x54 returns 0x1D010001.
- R5: A control write (offset 0x00) with bit 0 set while idle gives exactly one cycle of engine start and sets busy (status bit 0). Control bit 0 always reads back as 0.
- R6: A control write with bit 0 set while busy produces no start pulse.
- R7: Control bit 1 (early termination) and bits [12:8] (iteration limit) read back as written, even while busy. The engine configuration outputs change only at a start pulse.
- R8: Engine done clears busy and captures the result fields into status: bit 1 converged, bits [12:8] iterations used, bits [23:16] syndrome weight. It also captures the decoded bits shown at 0x50.
- R9: Reads from unmapped offsets return zero.
- R10: After reset, ACK, start and busy are low, all registers read zero, and every soft value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 8 | Byte address offset |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| eng_start_o | output | 1 | One-cycle decode launch |
| eng_early_term_o | output | 1 | Early-termination enable latched at start |
| eng_max_iter_o | output | 5 | Iteration limit latched at start |
| eng_done_i | input | 1 | Engine finished strobe |
| eng_converged_i | input | 1 | Parity checks all satisfied |
| eng_iters_i | input | 5 | Iterations used |
| eng_synd_wt_i | input | 8 | Residual syndrome weight |
| eng_bits_i | input | 32 | Decoded information bits |
| llr_rd_idx_i | input | 8 | Soft-value store read index |
| llr_rd_val_o | output | 6 | Soft value at that index |

## Verification
The bench builds the block with its defaults: 256 stored values, 6 bits each, five per word. This makes the 52-word window end on a partial word, so the tail write at 0xDC, with one live slot and four discarded, is reachable. The default map also places the read-side result registers inside the write window, so the overlap can be shown in both directions. The engine is driven directly from the bench, which gives control over busy periods and allows control writes to land in the middle of a decode.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int LLR_W     = 6;
    localparam int N_LLR     = 256;
    localparam int PER_WORD  = DATA_W / LLR_W;
    localparam int WIN_WORDS = (N_LLR + PER_WORD - 1) / PER_WORD;
    localparam int IDX_W     = $clog2(WIN_WORDS * PER_WORD);
    localparam int WIDX_W    = $clog2(WIN_WORDS);
    localparam int ITER_W    = 5;
    localparam int SYND_W    = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_WIN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_WEND = OFS_WIN + ADDR_W'(4 * (WIN_WORDS - 1));
    localparam logic [ADDR_W-1:0] OFS_BITS = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_VER  = 8'h54;
    localparam logic [DATA_W-1:0] ID_WORD  = 32'h1D01_0001;

    typedef struct packed {
        logic              early;
        logic [ITER_W-1:0] max_iter;
    } cfg_t;

    typedef struct packed {
        logic              conv;
        logic [ITER_W-1:0] iters;
        logic [SYND_W-1:0] synd;
    } res_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_STAT, SEL_BITS, SEL_VER, SEL_WIN
    } sel_e;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a, input logic we);
        sel_e s;
        s = SEL_NONE;
        if (we) begin
            if (a == OFS_CTRL) s = SEL_CTRL;
            else if (a >= OFS_WIN && a <= OFS_WEND && a[1:0] == 2'b00) s = SEL_WIN;
        end else begin
            case (a)
                OFS_CTRL: s = SEL_CTRL;
                OFS_STAT: s = SEL_STAT;
                OFS_BITS: s = SEL_BITS;
                OFS_VER:  s = SEL_VER;
                default:  s = SEL_NONE;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/sdec_wb_slave.sv
module sdec_wb_slave
    import sdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    output logic              ack,
    output logic              req,
    output sel_e              sel
);
    assign req = cyc && stb && !ack;
    assign sel = decode(adr, we);

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= req;
    end
endmodule

// File: rtl/sdec_llr_store.sv
module sdec_llr_store
    import sdec_pkg::*;
#(
    parameter int N     = N_LLR,
    parameter int W     = LLR_W,
    parameter int PER   = PER_WORD,
    localparam int RI_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RI_W-1:0]   rd_idx,
    output logic [W-1:0]      rd_val
);
    logic [W-1:0]     mem [N];
    logic [IDX_W-1:0] slot_idx [PER];
    logic             slot_ok  [PER];

    for (genvar k = 0; k < PER; k++) begin : g_slot
        assign slot_idx[k] = IDX_W'(word_idx) * IDX_W'(PER) + IDX_W'(k);
        assign slot_ok[k]  = slot_idx[k] < IDX_W'(N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < PER; k++) begin
                if (slot_ok[k]) mem[RI_W'(slot_idx[k])] <= wdata[k*W +: W];
            end
        end
    end

    assign rd_val = mem[rd_idx];
endmodule

// File: rtl/sdec_ctrl.sv
module sdec_ctrl
    import sdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  res_t              res_in,
    input  logic [DATA_W-1:0] bits_in,
    output cfg_t              cfg_shadow,
    output cfg_t              cfg_active,
    output logic              start,
    output logic              busy,
    output res_t              res_q,
    output logic [DATA_W-1:0] bits_q
);
    logic launch;
    assign launch = ctrl_wr && wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_shadow <= '0;
            cfg_active <= '0;
            start      <= 1'b0;
            busy       <= 1'b0;
            res_q      <= '0;
            bits_q     <= '0;
        end else begin
            start <= launch;
            if (ctrl_wr) begin
                cfg_shadow.early    <= wdata[1];
                cfg_shadow.max_iter <= wdata[8 +: ITER_W];
            end
            if (launch) begin
                cfg_active.early    <= wdata[1];
                cfg_active.max_iter <= wdata[8 +: ITER_W];
                busy                <= 1'b1;
            end else if (done) begin
                busy   <= 1'b0;
                res_q  <= res_in;
                bits_q <= bits_in;
            end
        end
    end
endmodule

// File: rtl/sdec_bus_regs.sv
module sdec_bus_regs
    import sdec_pkg::*;
#(
    parameter int NUM_LLR = N_LLR,
    localparam int RI_W   = $clog2(NUM_LLR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    output logic              eng_start_o,
    output logic              eng_early_term_o,
    output logic [ITER_W-1:0] eng_max_iter_o,
    input  logic              eng_done_i,
    input  logic              eng_converged_i,
    input  logic [ITER_W-1:0] eng_iters_i,
    input  logic [SYND_W-1:0] eng_synd_wt_i,
    input  logic [DATA_W-1:0] eng_bits_i,
    input  logic [RI_W-1:0]   llr_rd_idx_i,
    output logic [LLR_W-1:0]  llr_rd_val_o
);
    logic              req;
    sel_e              sel;
    cfg_t              cfg_shadow, cfg_active;
    logic              busy;
    res_t              res_in, res_q;
    logic [DATA_W-1:0] bits_q;
    logic [ADDR_W-1:0] win_ofs;
    logic [DATA_W-1:0] rd_mux;

    sdec_wb_slave u_slv (
        .clk(clk), .rst(rst), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
        .adr(wb_adr_i), .ack(wb_ack_o), .req(req), .sel(sel)
    );

    assign win_ofs = wb_adr_i - OFS_WIN;

    sdec_llr_store #(.N(NUM_LLR)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(req && wb_we_i && sel == SEL_WIN),
        .word_idx(win_ofs[2 +: WIDX_W]),
        .wdata(wb_dat_i),
        .rd_idx(llr_rd_idx_i),
        .rd_val(llr_rd_val_o)
    );

    assign res_in = '{conv: eng_converged_i, iters: eng_iters_i, synd: eng_synd_wt_i};

    sdec_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .ctrl_wr(req && wb_we_i && sel == SEL_CTRL),
        .wdata(wb_dat_i), .done(eng_done_i),
        .res_in(res_in), .bits_in(eng_bits_i),
        .cfg_shadow(cfg_shadow), .cfg_active(cfg_active),
        .start(eng_start_o), .busy(busy), .res_q(res_q), .bits_q(bits_q)
    );

    assign eng_early_term_o = cfg_active.early;
    assign eng_max_iter_o   = cfg_active.max_iter;

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: begin
                rd_mux[1]          = cfg_shadow.early;
                rd_mux[8 +: ITER_W] = cfg_shadow.max_iter;
            end
            SEL_STAT: begin
                rd_mux[0]           = busy;
                rd_mux[1]           = res_q.conv;
                rd_mux[8 +: ITER_W]  = res_q.iters;
                rd_mux[16 +: SYND_W] = res_q.synd;
            end
            SEL_BITS: rd_mux = bits_q;
            SEL_VER:  rd_mux = ID_WORD;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  wb_dat_o <= '0;
        else if (req && !wb_we_i) wb_dat_o <= rd_mux;
        else                      wb_dat_o <= '0;
    end
endmodule

// File: rtl/sdec_bus_regs_chk.sv
module sdec_bus_regs_chk
    import sdec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wb_cyc_i,
    input logic              wb_stb_i,
    input logic              wb_ack_o,
    input logic              eng_start_o,
    input logic              eng_early_term_o,
    input logic [ITER_W-1:0] eng_max_iter_o,
    input logic              eng_done_i,
    input logic              busy
);
    // R1
    ack_next_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);
    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |=> !wb_ack_o);
    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o);
    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> busy);
    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> eng_start_o);
    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(eng_max_iter_o) || !$stable(eng_early_term_o)) |-> eng_start_o);
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done_i && busy) |=> !busy);
endmodule

bind sdec_bus_regs sdec_bus_regs_chk u_chk (
    .clk(clk), .rst(rst), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
    .wb_ack_o(wb_ack_o), .eng_start_o(eng_start_o),
    .eng_early_term_o(eng_early_term_o), .eng_max_iter_o(eng_max_iter_o),
    .eng_done_i(eng_done_i), .busy(busy)
);

// File: tb/sdec_bus_regs_tb.sv
module sdec_bus_regs_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cyc = 0, stb = 0, we = 0;
    logic [7:0]  adr = 0;
    logic [31:0] wdat = 0, rdat;
    logic        ack, start, early;
    logic [4:0]  max_iter;
    logic        done = 0, conv = 0;
    logic [4:0]  iters = 0;
    logic [7:0]  synd = 0;
    logic [31:0] bits = 0;
    logic [7:0]  ridx = 0;
    logic [5:0]  rval;

    int checks = 0, errors = 0, start_cnt = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) if (start) start_cnt++;

    sdec_bus_regs u_dut (
        .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
        .eng_start_o(start), .eng_early_term_o(early), .eng_max_iter_o(max_iter),
        .eng_done_i(done), .eng_converged_i(conv), .eng_iters_i(iters),
        .eng_synd_wt_i(synd), .eng_bits_i(bits),
        .llr_rd_idx_i(ridx), .llr_rd_val_o(rval)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
        @(posedge clk); @(negedge clk);
        check("R1 write ack", 32'(ack), 1);
        cyc = 0; stb = 0; we = 0;
        @(posedge clk); @(negedge clk);
        check("R1 ack drop", 32'(ack), 0);
    endtask

    task automatic wb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 0; adr = a;
        @(posedge clk); @(negedge clk);
        check("R1 read ack", 32'(ack), 1);
        d = rdat;
        cyc = 0; stb = 0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic llr_at(input int i, input logic [5:0] exp, input string req);
        @(negedge clk);
        ridx = 8'(i);
        #1;
        check(req, 32'(rval), 32'(exp));
    endtask

    function automatic logic [31:0] pack5(input int base, input logic [1:0] top);
        logic [31:0] w;
        w = {top, 30'b0};
        for (int k = 0; k < 5; k++) w[k*6 +: 6] = 6'(base + k * 7);
        return w;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R10 ack", 32'(ack), 0);
        check("R10 start", 32'(start), 0);
        wb_read(8'h00, d); check("R10 ctrl", d, 0);
        wb_read(8'h04, d); check("R10 status", d, 0);
        wb_read(8'h50, d); check("R10 bits", d, 0);
        llr_at(0, 0, "R10 llr0");
        llr_at(255, 0, "R10 llr255");
    endtask

    task automatic t_unpack();
        wb_write(8'h10, pack5(1, 2'b11));
        wb_write(8'h1C, pack5(20, 2'b10));
        for (int k = 0; k < 5; k++) llr_at(k, 6'(1 + k * 7), "R2 word0");
        for (int k = 0; k < 5; k++) llr_at(15 + k, 6'(20 + k * 7), "R2 word3");
        llr_at(5, 0, "R2 neighbour");
    endtask

    task automatic t_tail();
        wb_write(8'hD8, pack5(3, 2'b00));
        wb_write(8'hDC, pack5(40, 2'b11));
        for (int k = 0; k < 5; k++) llr_at(250 + k, 6'(3 + k * 7), "R3 prev word");
        llr_at(255, 6'(40), "R3 last slot");
    endtask

    task automatic t_overlap();
        logic [31:0] d;
        wb_write(8'h50, pack5(9, 2'b01));
        wb_write(8'h54, pack5(11, 2'b00));
        for (int k = 0; k < 5; k++) llr_at(80 + k, 6'(9 + k * 7), "R4 win 0x50");
        for (int k = 0; k < 5; k++) llr_at(85 + k, 6'(11 + k * 7), "R4 win 0x54");
        wb_read(8'h50, d); check("R4 bits read", d, 0);
        wb_read(8'h54, d); check("R4 version", d, 32'h1D010001);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        int c0;
        c0 = start_cnt;
        wb_write(8'h00, 32'h0000_1E03);
        repeat (3) @(negedge clk);
        check("R5 one pulse", 32'(start_cnt - c0), 1);
        check("R5 max_iter", 32'(max_iter), 30);
        check("R5 early", 32'(early), 1);
        wb_read(8'h04, d); check("R5 busy", d, 1);
        wb_read(8'h00, d); check("R5 ctrl readback", d, 32'h1E02);
        c0 = start_cnt;
        wb_write(8'h00, 32'h0000_0701);
        repeat (3) @(negedge clk);
        check("R6 no pulse", 32'(start_cnt - c0), 0);
        check("R7 max_iter held", 32'(max_iter), 30);
        check("R7 early held", 32'(early), 1);
        wb_read(8'h00, d); check("R7 shadow", d, 32'h0700);
        @(negedge clk);
        done = 1; conv = 1; iters = 12; synd = 3; bits = 32'hCAFE_F00D;
        @(negedge clk);
        done = 0; conv = 0; iters = 0; synd = 0; bits = 0;
        wb_read(8'h04, d); check("R8 status", d, 32'h0003_0C02);
        wb_read(8'h50, d); check("R8 bits", d, 32'hCAFE_F00D);
        c0 = start_cnt;
        wb_write(8'h00, 32'h0000_0701);
        repeat (2) @(negedge clk);
        check("R7 new start", 32'(start_cnt - c0), 1);
        check("R7 max_iter new", 32'(max_iter), 7);
        check("R7 early new", 32'(early), 0);
        @(negedge clk); done = 1; @(negedge clk); done = 0;
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wb_read(8'h08, d); check("R9 0x08", d, 0);
        wb_read(8'hE0, d); check("R9 0xE0", d, 0);
        wb_read(8'h10, d); check("R9 window read", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_unpack();
        t_tail();
        t_overlap();
        t_decode();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule